// File: doc/BRIEF.md
# Colour Palette Table with Serial Loader

This block maps 8-bit pixel codes to 24-bit RGB colours. The table has one entry per possible code. Software fills it through a narrow byte-wide port that has two registers. The pointer register selects the first entry to load. The component register takes one colour byte on each write.

The loader keeps track of which colour byte comes next. After every third byte it moves to the next entry without help from software. A single pointer write followed by a stream of bytes therefore fills any run of entries, the whole table included. An entry is written to storage as one word, and only when its last byte arrives. The display side can never see a half-written colour.

The lookup path runs on its own. A pixel code presented at one clock edge gives its colour on `rgb_out` after that edge. Writes on the register port never stall it.

Top module: `clut_loader`

## Requirements
- R1: After reset the entry pointer is 0, the next expected byte is red, and `rgb_out` is 0.
- R2: A write with `wr_sel` = 0 (pointer register) loads `wr_data` into the entry pointer. It also drops any colour bytes already collected, so the next component write is taken as red.
- R3: Component writes (`wr_sel` = 1) are taken in the order red, green, blue. The stored entry packs red in bits 23:16, green in bits 15:8 and blue in bits 7:0.
- R4: The blue write of an entry advances the entry pointer by one, and the pointer wraps from 255 to 0. A pointer write followed by 768 component writes therefore loads all 256 entries.
- R5: An entry keeps its previous contents until the blue byte of its new triple is written. A lookup after only red, or after red and green, returns the old colour.
- R6: `rgb_out` shows the entry selected by the `pix_idx` value sampled at the last rising edge. It does not follow `pix_idx` between edges.
- R7: A lookup can fall in the same cycle as the commit of the same entry. In that case the lookup returns the contents from before the commit, and the next lookup returns the new colour.
- R8: While `wr_en` is 0, `wr_sel` and `wr_data` have no effect on the pointer, the component position or the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_sel | input | 1 | 0 selects the pointer register, 1 selects the component register |
| wr_data | input | 8 | Write byte |
| pix_idx | input | 8 | Pixel code to look up |
| rgb_out | output | 24 | Colour of the pixel code sampled at the previous edge |

## Verification
Two functions can land in the same cycle: the commit of a blue byte, and a lookup of the entry that the commit writes. The bench sets up this case on purpose. It loads red and green of a new triple, then drives the blue write in the same cycle that `pix_idx` points at that entry. The result must be the old colour right after that edge and the new colour one edge later. With this ordering the bench can tell a read-first table from one that forwards the write or commits early. The bench also stops a triple halfway with a pointer write and checks that the abandoned entry still holds its old colour.

// File: rtl/clut_pkg.sv
package clut_pkg;
   typedef enum logic {
      SEL_PTR  = 1'b0,
      SEL_COMP = 1'b1
   } reg_sel_e;
endpackage

// File: rtl/clut_seq.sv
module clut_seq
   import clut_pkg::*;
#(
   parameter int IDX_W    = 8,
   parameter int COMP_W   = 8,
   parameter int COMP_CNT = 3,
   localparam int CNT_W   = $clog2(COMP_CNT),
   localparam int ENT_W   = COMP_W * COMP_CNT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_sel,
   input  logic [COMP_W-1:0] wr_data,
   output logic              commit,
   output logic [IDX_W-1:0]  commit_addr,
   output logic [ENT_W-1:0]  commit_word,
   output logic [IDX_W-1:0]  ptr_o,
   output logic [CNT_W-1:0]  comp_o
);
   logic [IDX_W-1:0]  ptr_q;
   logic [CNT_W-1:0]  comp_q;
   logic              ptr_wr, comp_wr, last_comp;
   logic [COMP_W-1:0] stage_q [COMP_CNT-1];

   assign ptr_wr    = wr_en && (reg_sel_e'(wr_sel) == SEL_PTR);
   assign comp_wr   = wr_en && (reg_sel_e'(wr_sel) == SEL_COMP);
   assign last_comp = (comp_q == CNT_W'(COMP_CNT - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q  <= '0;
         comp_q <= '0;
      end else if (ptr_wr) begin
         ptr_q  <= wr_data[IDX_W-1:0];
         comp_q <= '0;
      end else if (comp_wr) begin
         if (last_comp) begin
            comp_q <= '0;
            ptr_q  <= ptr_q + 1'b1;
         end else begin
            comp_q <= comp_q + 1'b1;
         end
      end
   end

   for (genvar g = 0; g < COMP_CNT - 1; g++) begin : g_stage
      always_ff @(posedge clk) begin
         if (comp_wr && comp_q == CNT_W'(g))
            stage_q[g] <= wr_data;
      end
      assign commit_word[ENT_W-1-g*COMP_W -: COMP_W] = stage_q[g];
   end
   assign commit_word[COMP_W-1:0] = wr_data;

   assign commit      = comp_wr && last_comp;
   assign commit_addr = ptr_q;
   assign ptr_o       = ptr_q;
   assign comp_o      = comp_q;
endmodule

// File: rtl/clut_store.sv
module clut_store #(
   parameter int IDX_W      = 8,
   parameter int ENT_W      = 24,
   parameter bit WRITE_THRU = 1'b0,
   localparam int DEPTH     = 1 << IDX_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [IDX_W-1:0] wa,
   input  logic [ENT_W-1:0] wd,
   input  logic [IDX_W-1:0] ra,
   output logic [ENT_W-1:0] rd
);
   logic [ENT_W-1:0] mem [DEPTH];
   logic [ENT_W-1:0] rd_next;

   always_ff @(posedge clk) begin
      if (we) mem[wa] <= wd;
   end

   if (WRITE_THRU) begin : g_fwd
      assign rd_next = (we && wa == ra) ? wd : mem[ra];
   end else begin : g_rfirst
      assign rd_next = mem[ra];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd <= '0;
      else        rd <= rd_next;
   end
endmodule

// File: rtl/clut_loader.sv
module clut_loader #(
   parameter int IDX_W      = 8,
   parameter int COMP_W     = 8,
   parameter int COMP_CNT   = 3,
   parameter bit WRITE_THRU = 1'b0,
   localparam int CNT_W     = $clog2(COMP_CNT),
   localparam int ENT_W     = COMP_W * COMP_CNT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_sel,
   input  logic [COMP_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  pix_idx,
   output logic [ENT_W-1:0]  rgb_out
);
   if (COMP_CNT < 2) begin : g_bad_cnt
      $error("clut_loader: COMP_CNT must be at least 2");
   end
   if (IDX_W > COMP_W) begin : g_bad_idx
      $error("clut_loader: pointer must fit one write byte");
   end
   if (IDX_W > 12) begin : g_bad_depth
      $error("clut_loader: table depth too large");
   end

   logic              commit;
   logic [IDX_W-1:0]  commit_addr;
   logic [ENT_W-1:0]  commit_word;
   logic [IDX_W-1:0]  seq_ptr;
   logic [CNT_W-1:0]  seq_comp;

   clut_seq #(.IDX_W(IDX_W), .COMP_W(COMP_W), .COMP_CNT(COMP_CNT)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_sel     (wr_sel),
      .wr_data    (wr_data),
      .commit     (commit),
      .commit_addr(commit_addr),
      .commit_word(commit_word),
      .ptr_o      (seq_ptr),
      .comp_o     (seq_comp)
   );

   clut_store #(.IDX_W(IDX_W), .ENT_W(ENT_W), .WRITE_THRU(WRITE_THRU)) u_store (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (commit),
      .wa   (commit_addr),
      .wd   (commit_word),
      .ra   (pix_idx),
      .rd   (rgb_out)
   );
endmodule

// File: rtl/clut_loader_chk.sv
module clut_loader_chk #(
   parameter int IDX_W    = 8,
   parameter int COMP_W   = 8,
   parameter int COMP_CNT = 3,
   localparam int CNT_W   = $clog2(COMP_CNT)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              wr_sel,
   input logic [COMP_W-1:0] wr_data,
   input logic [IDX_W-1:0]  ptr,
   input logic [CNT_W-1:0]  comp
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(COMP_CNT - 1);

   p_ptr_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_sel) |=> (ptr == $past(wr_data[IDX_W-1:0]) && comp == '0));

   p_comp_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel && comp != LAST) |=> (comp == $past(comp) + 1'b1 && ptr == $past(ptr)));

   p_comp_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      comp <= LAST);

   p_entry_adv_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel && comp == LAST) |=> (ptr == IDX_W'($past(ptr) + 1'b1) && comp == '0));

   p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ($stable(ptr) && $stable(comp)));
endmodule

bind clut_loader clut_loader_chk #(.IDX_W(IDX_W), .COMP_W(COMP_W), .COMP_CNT(COMP_CNT)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .wr_en  (wr_en),
   .wr_sel (wr_sel),
   .wr_data(wr_data),
   .ptr    (seq_ptr),
   .comp   (seq_comp)
);

// File: tb/sim_clut_loader.sv
`timescale 1ns/1ps
module sim_clut_loader;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        wr_sel = 1'b0;
   logic [7:0]  wr_data = '0;
   logic [7:0]  pix_idx = '0;
   logic [23:0] rgb_out;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;
   logic [23:0] model [256];

   always #5 clk = ~clk;

   clut_loader u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .pix_idx(pix_idx), .rgb_out(rgb_out)
   );

   function automatic logic [23:0] pat(int i, int salt);
      logic [7:0] r, g, b;
      r = 8'(i ^ 8'h5A ^ salt);
      g = 8'(i * 3 + salt);
      b = 8'(~i + salt * 7);
      return {r, g, b};
   endfunction

   task automatic check(string req, logic [23:0] act, logic [23:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%06h expected=%06h", req, act, exp);
      end
   endtask

   task automatic wr(logic sel, logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wr_triple(logic [23:0] t);
      wr(1'b1, t[23:16]);
      wr(1'b1, t[15:8]);
      wr(1'b1, t[7:0]);
   endtask

   task automatic look(string req, int idx);
      @(negedge clk);
      pix_idx = 8'(idx);
      @(negedge clk);
      check(req, rgb_out, model[idx]);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [23:0] t;
      repeat (3) @(negedge clk);
      check("R1 reset output", rgb_out, 24'h0);
      rst_n = 1'b1;

      // R4/R3: one pointer write then 768 component writes fill the table
      wr(1'b0, 8'd0);
      for (int i = 0; i < 256; i++) begin
         model[i] = pat(i, 0);
         wr_triple(model[i]);
      end
      // R1: a fresh reset would start at entry 0; here the pointer has wrapped to 0
      for (int i = 0; i < 256; i++) look("R3 R4 sweep", i);

      // R4: wrap from 255 to 0
      wr(1'b0, 8'd255);
      model[255] = 24'h123456; wr_triple(model[255]);
      model[0]   = 24'hABCDEF; wr_triple(model[0]);
      look("R4 wrap last", 255);
      look("R4 wrap first", 0);
      look("R4 wrap neighbour", 1);

      // R2: pointer write in mid-triple restarts at red
      wr(1'b0, 8'd10);
      wr(1'b1, 8'hEE); wr(1'b1, 8'hDD);
      wr(1'b0, 8'd20);
      model[20] = 24'h0F1E2D; wr_triple(model[20]);
      look("R2 abandoned entry unchanged", 10);
      look("R2 restarted entry", 20);
      look("R2 no spill to next", 11);

      // R5: partial entry invisible until blue
      wr(1'b0, 8'd30);
      wr(1'b1, 8'h77);
      look("R5 after red", 30);
      wr(1'b1, 8'h88);
      look("R5 after green", 30);
      wr(1'b1, 8'h99);
      model[30] = 24'h778899;
      look("R5 after blue", 30);

      // R8: strobe low ignores sel/data; next triple goes to entry 31
      @(negedge clk);
      wr_sel = 1'b0; wr_data = 8'd200;
      @(negedge clk);
      wr_sel = 1'b1; wr_data = 8'h11;
      @(negedge clk);
      model[31] = 24'hC0FFEE; wr_triple(model[31]);
      look("R8 pointer kept", 31);
      look("R8 no pointer load", 200);

      // R6: output changes only at the edge
      look("R6 first", 7);
      @(negedge clk);
      pix_idx = 8'd5;
      #1;
      check("R6 no combinational path", rgb_out, model[7]);
      @(negedge clk);
      check("R6 one-cycle latency", rgb_out, model[5]);

      // R7: commit and lookup of same entry in one cycle
      wr(1'b0, 8'd40);
      wr(1'b1, 8'h4A); wr(1'b1, 8'h4B);
      @(negedge clk);
      pix_idx = 8'd40;
      wr_en = 1'b1; wr_sel = 1'b1; wr_data = 8'h4C;
      @(negedge clk);
      wr_en = 1'b0;
      check("R7 read-first on collision", rgb_out, model[40]);
      model[40] = 24'h4A4B4C;
      @(negedge clk);
      check("R7 new value next cycle", rgb_out, model[40]);

      // R2/R3: reload a run with a different pattern and verify it
      wr(1'b0, 8'd100);
      for (int i = 100; i < 110; i++) begin
         t = pat(i, 9); model[i] = t; wr_triple(t);
      end
      for (int i = 98; i < 112; i++) look("R3 reload run", i);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule